// File: doc/BRIEF.md
# Single-Comparator Tracking Quantizer

This block is the digital half of a nine-level quantizer that shares one analog comparator across eight thresholds. On every sample tick it reads the comparator's decision about the one threshold it is currently presenting. It then moves its level by at most one step and picks the threshold to present next. The level runs from 0, with every output segment off, up to 8, with all eight segments on. It drives an eight-bit thermometer segment-enable vector that selects the operating point of a segmented power stage. It also drives a three-bit code for the analog multiplexer that routes one reference voltage to the comparator.

Threshold index j lies between level j and level j+1. At level L the block tests either the threshold above it (index L) or the one below it (index L-1). It alternates between the two on successive ticks. At the two ends it is forced to test the only neighbour that exists. A rising filtered error therefore climbs the level one threshold at a time, and a falling one descends it. The comparator bit is asynchronous to the clock and passes through a two-flop synchronizer. Sample ticks must be at least three clock cycles apart, so that a new reference has settled through the synchronizer before it is used. `rst_n` is asynchronous on assertion and is expected to be released in step with `clk` by the reset tree.

Top module: `tq_quantizer`

## Requirements
- R1: While `rst_n` is low, `level` is 0, `seg_en` is all zero and `ref_sel` is 0. The first tick after reset tests the upper threshold.
- R2: `ref_sel` always names a neighbour of the present level: either `level` (the upper test) or `level-1` (the lower test). It never names an index outside 0 to 7.
- R3: `level` changes only on a clock edge where `samp_en` is high, and then by at most one step.
- R4: `cmp_in` high means the filtered error lies above the presented reference. On an upper test a high decision raises the level by one. On a lower test a low decision lowers it by one. Every other outcome keeps the level.
- R5: The test direction alternates on every tick, starting with the upper test. At level 0 the upper test (`ref_sel`=0) is always used, and at level 8 the lower test (`ref_sel`=7) is always used. The alternation still advances on those ticks.
- R6: `seg_en` is thermometer coded: at level k, bits 0 to k-1 are set and all higher bits are clear.
- R7: The decision used at a tick is the value of `cmp_in` sampled two clock edges before the tick edge. A pulse on `cmp_in` that is present only at the edge just before the tick has no effect on the level.
- R8: With a constant error between two adjacent thresholds, the level settles within 20 ticks at the number of thresholds lying below the error. It then stays there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | One-cycle sample tick |
| cmp_in | input | 1 | Comparator decision, asynchronous to clk |
| ref_sel | output | 3 | Index of the threshold presented to the comparator |
| level | output | 4 | Present quantization level, 0 to 8 |
| seg_en | output | 8 | Thermometer segment-enable vector |

## Verification
Two functions can land on the same tick: the step taken from the decision and the end-of-range redirection of the test direction. For example, when the level reaches 8, the alternation may call for an upper test in the very next tick, and the block must present threshold 7 instead. The bench provokes this by driving the modelled error far above the top threshold and then far below the bottom one. It also sweeps the error up and down across every threshold gap. On every tick it compares `ref_sel`, `level` and `seg_en` with an arithmetic model. The same model also judges a forced comparator pulse that is too late to pass the synchronizer.

// File: rtl/tq_pkg.sv
`timescale 1ns/1ps
package tq_pkg;
  // Direction the alternation asks for on the next tick
  typedef enum logic {
    PH_UP = 1'b0,
    PH_DN = 1'b1
  } phase_e;
endpackage

// File: rtl/tq_sync.sv
`timescale 1ns/1ps
module tq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tq_tracker.sv
`timescale 1ns/1ps
module tq_tracker
  import tq_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int LVL_W   = $clog2(NUM_SEG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_en,
  input  logic             cmp_s,
  output logic [LVL_W-1:0] level,
  output logic             test_up
);
  localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(NUM_SEG);
  localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);

  phase_e           phase_q, phase_d;
  logic [LVL_W-1:0] lvl_d;
  logic             at_floor, at_top;

  // Direction in force this tick: ends override the alternation
  always_comb begin
    at_floor = (level == '0);
    at_top   = (level == LVL_TOP);
    test_up  = at_floor | (!at_top & (phase_q == PH_UP));
  end

  // Next state
  always_comb begin
    lvl_d   = level;
    phase_d = phase_q;
    if (samp_en) begin
      phase_d = (phase_q == PH_UP) ? PH_DN : PH_UP;
      if (test_up && cmp_s)
        lvl_d = level + LVL_ONE;
      else if (!test_up && !cmp_s)
        lvl_d = level - LVL_ONE;
    end
  end

  // State registers, written only on a sample tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= '0;
      phase_q <= PH_UP;
    end else if (samp_en) begin
      level   <= lvl_d;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/tq_decode.sv
`timescale 1ns/1ps
module tq_decode #(
  parameter int NUM_SEG = 8,
  parameter int LVL_W   = $clog2(NUM_SEG + 1),
  parameter int SEL_W   = $clog2(NUM_SEG)
) (
  input  logic [LVL_W-1:0]   level,
  input  logic               test_up,
  output logic [SEL_W-1:0]   ref_sel,
  output logic [NUM_SEG-1:0] seg_en
);
  logic [LVL_W-1:0] idx;

  // Upper neighbour shares the level's index; lower one sits one below
  always_comb begin
    idx     = test_up ? level : (level - LVL_W'(1));
    ref_sel = idx[SEL_W-1:0];
  end

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_therm
    assign seg_en[i] = (level > LVL_W'(i));
  end
endmodule

// File: rtl/tq_quantizer.sv
`timescale 1ns/1ps
module tq_quantizer #(
  parameter  int NUM_SEG     = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int LVL_W       = $clog2(NUM_SEG + 1),
  localparam int SEL_W       = $clog2(NUM_SEG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               samp_en,
  input  logic               cmp_in,
  output logic [SEL_W-1:0]   ref_sel,
  output logic [LVL_W-1:0]   level,
  output logic [NUM_SEG-1:0] seg_en
);
  logic cmp_s;
  logic test_up;

  tq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cmp_in),
    .q     (cmp_s)
  );

  tq_tracker #(.NUM_SEG(NUM_SEG), .LVL_W(LVL_W)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .samp_en (samp_en),
    .cmp_s   (cmp_s),
    .level   (level),
    .test_up (test_up)
  );

  tq_decode #(.NUM_SEG(NUM_SEG), .LVL_W(LVL_W), .SEL_W(SEL_W)) u_dec (
    .level   (level),
    .test_up (test_up),
    .ref_sel (ref_sel),
    .seg_en  (seg_en)
  );
endmodule

// File: rtl/tq_quantizer_chk.sv
`timescale 1ns/1ps
module tq_quantizer_chk #(
  parameter int NUM_SEG = 8,
  parameter int LVL_W   = $clog2(NUM_SEG + 1),
  parameter int SEL_W   = $clog2(NUM_SEG)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               samp_en,
  input logic [SEL_W-1:0]   ref_sel,
  input logic [LVL_W-1:0]   level,
  input logic [NUM_SEG-1:0] seg_en
);
  localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(NUM_SEG);
  localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);

  a_r1_reset_level: assert property (@(posedge clk)
    !rst_n |-> (level == '0 && seg_en == '0 && ref_sel == '0));

  a_r2_ref_neighbour: assert property (@(posedge clk) disable iff (!rst_n)
    (LVL_W'(ref_sel) == level) || (LVL_W'(ref_sel) + LVL_ONE == level));

  a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en |=> $stable(level));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en |=> (level == $past(level) || level == $past(level) + LVL_ONE ||
                 level == $past(level) - LVL_ONE));

  a_r5_floor_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> (ref_sel == '0));

  a_r5_top_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_TOP) |-> (ref_sel == SEL_W'(NUM_SEG - 1)));

  a_r6_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(seg_en) == int'(level)) && ((seg_en & (seg_en + NUM_SEG'(1))) == '0));
endmodule

bind tq_quantizer tq_quantizer_chk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .samp_en (samp_en),
  .ref_sel (ref_sel),
  .level   (level),
  .seg_en  (seg_en)
);

// File: tb/tq_quantizer_tb.sv
`timescale 1ns/1ps
module tq_quantizer_tb;
  logic       clk;
  logic       rst_n;
  logic       samp_en;
  logic       cmp_in;
  logic [2:0] ref_sel;
  logic [3:0] level;
  logic [7:0] seg_en;

  int  vin;
  logic force_en;
  logic force_val;
  int  checks;
  int  errors;
  int  m_level;
  int  m_phase;
  bit  done;

  tq_quantizer u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .samp_en (samp_en),
    .cmp_in  (cmp_in),
    .ref_sel (ref_sel),
    .level   (level),
    .seg_en  (seg_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural comparator: threshold j sits at 16*(j+1)
  always_comb begin
    if (force_en) cmp_in = force_val;
    else          cmp_in = (vin > 16 * (int'(ref_sel) + 1));
  end

  function automatic int quant(input int v);
    int n = 0;
    for (int j = 0; j < 8; j++) if (v > 16 * (j + 1)) n++;
    return n;
  endfunction

  function automatic int exp_up();
    if (m_level == 0) return 1;
    if (m_level == 8) return 0;
    return (m_phase == 0) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all();
    int e_ref = exp_up() ? m_level : m_level - 1;
    chk("R4 level", int'(level), m_level);
    chk("R6 seg_en", int'(seg_en), (1 << m_level) - 1);
    if (m_level == 0 || m_level == 8) chk("R5 end ref_sel", int'(ref_sel), e_ref);
    else                              chk("R2 ref_sel", int'(ref_sel), e_ref);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      chk("R3 hold", int'(level), m_level);
    end
  endtask

  // Called at a negedge; mode <0 uses the modelled comparator, else the forced decision
  task automatic tick(input int mode);
    int up  = exp_up();
    int idx = up ? m_level : m_level - 1;
    int c   = (mode < 0) ? ((vin > 16 * (idx + 1)) ? 1 : 0) : mode;
    samp_en = 1'b1;
    @(posedge clk);
    if (up == 1 && c == 1)      m_level++;
    else if (up == 0 && c == 0) m_level--;
    m_phase ^= 1;
    @(negedge clk);
    samp_en = 1'b0;
    check_all();
  endtask

  task automatic run(input int n);
    repeat (n) begin
      idle(3);
      tick(-1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; samp_en = 1'b0; vin = 0;
    force_en = 1'b0; force_val = 1'b0;
    m_level = 0; m_phase = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset level", int'(level), 0);
    chk("R1 reset seg_en", int'(seg_en), 0);
    chk("R1 reset ref_sel", int'(ref_sel), 0);
    rst_n = 1'b1;
    idle(3);

    // R8: upward then downward sweep across every threshold gap
    for (int v = 0; v <= 150; v += 5) begin
      vin = v;
      run(20);
      chk("R8 settled up", int'(level), quant(v));
    end
    for (int v = 150; v >= 0; v -= 7) begin
      vin = v;
      run(20);
      chk("R8 settled down", int'(level), quant(v));
    end

    // R5: saturation at both ends with the alternation still running
    vin = 250;
    run(24);
    chk("R5 top level", int'(level), 8);
    chk("R5 top ref_sel", int'(ref_sel), 7);
    vin = 0;
    run(24);
    chk("R5 floor level", int'(level), 0);
    chk("R5 floor ref_sel", int'(ref_sel), 0);

    // R3: a large input with no tick leaves the level alone
    vin = 250;
    idle(12);
    chk("R3 no tick level", int'(level), 0);
    vin = 0;
    idle(3);

    // R7: a pulse that only reaches the first sync stage is ignored
    force_val = 1'b1;
    force_en  = 1'b1;
    @(negedge clk);
    force_en  = 1'b0;
    tick(0);
    chk("R7 late pulse ignored", int'(level), 0);
    idle(3);
    force_en = 1'b1;
    idle(3);
    tick(1);
    chk("R7 held decision used", int'(level), 1);
    force_en = 1'b0;

    // R1: asynchronous reset in mid-run
    vin = 100;
    run(20);
    chk("R8 settled mid", int'(level), quant(100));
    rst_n = 1'b0;
    #1;
    chk("R1 async level", int'(level), 0);
    chk("R1 async seg_en", int'(seg_en), 0);
    chk("R1 async ref_sel", int'(ref_sel), 0);
    m_level = 0; m_phase = 0;
    @(negedge clk);
    rst_n = 1'b1;
    run(20);
    chk("R8 settled after reset", int'(level), quant(100));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule